// File: doc/BRIEF.md
# Dual-Mode Word Serializer

This block converts parallel transmit words into a single-bit serial stream. It runs in one clock domain. A bit-rate enable, `bit_en`, marks every serial bit slot. The block counts ten enables per word period and derives a reference clock, `ref_clk`, from that count. The data source uses `ref_clk` to place its words. A rising edge of `ref_clk` begins each word period, and a falling edge falls halfway through it.

Two capture modes exist, and the block reads the mode pin only while reset is held.

- **Ten-bit mode:** the whole 10-bit word is taken at the rising reference edge.
- **Double-rate mode:** two 5-bit halves are taken from the low input lines, one at the rising edge and one at the falling edge.

Each finished word passes through a fixed pipeline into a shift register. The shift register sends the word least significant bit first, and the next word follows with no gap. The delay from loading a word to sending its last bit is fixed for each mode. It is 19 bit times in ten-bit mode and 29 bit times in double-rate mode.

Top module: `sertx_top`

## Requirements
- R1: The serial output sends each word bit 0 first through bit 9 last, one bit per enabled cycle, and the next word's bit 0 follows bit 9 with no idle slot.
- R2: In ten-bit mode (`mode_ddr` low at reset), the full `tx_data[9:0]` is taken on every enabled cycle whose enable count since reset is a multiple of ten (10, 20, ...). Its bit 9 appears on `ser_out` after the 19th enable following that capture.
- R3: In double-rate mode (`mode_ddr` high at reset), `tx_data[4:0]` taken at enable count 10k becomes bits 0-4 of a word. `tx_data[4:0]` taken at enable count 10k+5 becomes bits 5-9 of the same word. `tx_data[9:5]` is ignored. Bit 9 appears 29 enables after the first half is captured.
- R4: After reset, `ser_out` stays low until the first complete word reaches the shift register. A falling-edge half with no earlier rising-edge half yields no word.
- R5: `ser_out` and `ref_clk` change only on cycles where `bit_en` is high; a cycle with `bit_en` low leaves both unchanged.
- R6: `ref_clk` is high when the enable count since reset, modulo ten, is 0 to 4, and low when it is 5 to 9.
- R7: `mode_ddr` is latched only while reset is asserted; a change of `mode_ddr` after reset has no effect on capture or latency.
- R8: A synchronous active-low reset clears the pipeline, drives `ser_out` low and `ref_clk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit slot enable, one per serial bit |
| mode_ddr | input | 1 | 1 = double-rate half-word capture, 0 = ten-bit capture; sampled during reset |
| tx_data | input | 10 | Parallel transmit word (low 5 bits in double-rate mode) |
| ref_clk | output | 1 | Derived reference clock, one period per word |
| ser_out | output | 1 | Serial data output |

## Verification
The shift register loads a new word, and the capture stage takes the next word, on the same enabled cycle at every word boundary. In double-rate mode, the pipeline stage also advances on that cycle. The bench keeps `bit_en` high on many consecutive cycles, so every boundary hits this collision. It also inserts random stall cycles so the collision occurs after gaps. A behavioural model maps each capture to the ten exact enable counts of its bits. On every cycle that model is compared with `ser_out` and `ref_clk`, so a word overwritten early or loaded late shows up as a wrong bit at a known slot.

// File: rtl/sertx_pkg.sv
// Package: shared mode type for the serializer.
// Assumes: mode encoding matches the mode_ddr pin (1 = double-rate).
package sertx_pkg;
    typedef enum logic {
        MODE_TEN = 1'b0,
        MODE_DDR = 1'b1
    } tx_mode_e;
endpackage

// File: rtl/sertx_bit_timer.sv
// Module: sertx_bit_timer
// Counts bit slots within a word period and derives the reference clock
// plus the boundary (rising edge) and middle (falling edge) strobes.
// Assumes WORD_W is even and at least 4.
module sertx_bit_timer #(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic wrap_stb,
    output logic mid_stb,
    output logic ref_clk
);
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;

    logic [CNT_W-1:0] slot_cnt;

    // Strobes fire on the enabled slot that ends a word or its first half.
    assign wrap_stb = bit_en && (slot_cnt == CNT_W'(WORD_W - 1));
    assign mid_stb  = bit_en && (slot_cnt == CNT_W'(HALF_W - 1));

    // Slot counter: advances once per enabled bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
        end else if (bit_en) begin
            slot_cnt <= wrap_stb ? '0 : slot_cnt + 1'b1;
        end
    end

    // Reference clock: high for the first half of each word period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_clk <= 1'b1;
        end else if (wrap_stb) begin
            ref_clk <= 1'b1;
        end else if (mid_stb) begin
            ref_clk <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_capture.sv
// Module: sertx_capture
// Captures a transmit word: whole word at the boundary in ten-bit mode,
// or two half words (boundary then middle) in double-rate mode.
// Assumes mode is stable outside reset.
module sertx_capture
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_mode_e          mode,
    input  logic              wrap_stb,
    input  logic              mid_stb,
    input  logic [WORD_W-1:0] tx_data,
    output logic [WORD_W-1:0] word,
    output logic              word_vld
);
    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] lo_half;
    logic              lo_vld;

    // Low half register: rising-edge sample for double-rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_half <= '0;
            lo_vld  <= 1'b0;
        end else if (wrap_stb && mode == MODE_DDR) begin
            lo_half <= tx_data[HALF_W-1:0];
            lo_vld  <= 1'b1;
        end
    end

    // Word register: assembled word and its validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            word_vld <= 1'b0;
        end else if (mode == MODE_TEN) begin
            if (wrap_stb) begin
                word     <= tx_data;
                word_vld <= 1'b1;
            end
        end else if (mid_stb) begin
            word     <= {tx_data[HALF_W-1:0], lo_half};
            word_vld <= lo_vld;
        end
    end
endmodule

// File: rtl/sertx_pipe.sv
// Module: sertx_pipe
// Delays the captured word by one extra word period in double-rate mode,
// giving each mode its fixed latency. Ten-bit mode passes straight through.
module sertx_pipe
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_mode_e          mode,
    input  logic              wrap_stb,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_vld,
    output logic [WORD_W-1:0] out_word,
    output logic              out_vld
);
    logic [WORD_W-1:0] hold_word;
    logic              hold_vld;

    // Hold stage: takes the assembled word at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_vld  <= 1'b0;
        end else if (wrap_stb) begin
            hold_word <= in_word;
            hold_vld  <= in_vld;
        end
    end

    // Mode mux: pick the path length for the selected mode.
    always_comb begin
        if (mode == MODE_DDR) begin
            out_word = hold_word;
            out_vld  = hold_vld;
        end else begin
            out_word = in_word;
            out_vld  = in_vld;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
// Module: sertx_shifter
// Loads a word at each boundary and shifts it out LSB first, one bit per
// enabled slot. Loads zero when no valid word is available.
module sertx_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              word_vld,
    output logic              ser_out
);
    logic [WORD_W-1:0] shreg;

    // Shift register: load on boundary, shift right otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bit_en) begin
            if (load) begin
                shreg <= word_vld ? word : '0;
            end else begin
                shreg <= {1'b0, shreg[WORD_W-1:1]};
            end
        end
    end

    assign ser_out = shreg[0];
endmodule

// File: rtl/sertx_top.sv
// Module: sertx_top
// Dual-mode parallel-to-serial transmitter. Latches the capture mode
// during reset, times word periods from bit enables, captures words,
// and serializes them with a fixed per-mode latency.
// Assumes ten bit enables per reference period (WORD_W = 10 default).
module sertx_top
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              mode_ddr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              ref_clk,
    output logic              ser_out
);
    tx_mode_e          mode_q;
    logic              wrap_stb;
    logic              mid_stb;
    logic [WORD_W-1:0] cap_word;
    logic              cap_vld;
    logic [WORD_W-1:0] pipe_word;
    logic              pipe_vld;

    // Mode latch: follows the pin only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= tx_mode_e'(mode_ddr);
        end
    end

    sertx_bit_timer #(.WORD_W(WORD_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .wrap_stb (wrap_stb),
        .mid_stb  (mid_stb),
        .ref_clk  (ref_clk)
    );

    sertx_capture #(.WORD_W(WORD_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .wrap_stb (wrap_stb),
        .mid_stb  (mid_stb),
        .tx_data  (tx_data),
        .word     (cap_word),
        .word_vld (cap_vld)
    );

    sertx_pipe #(.WORD_W(WORD_W)) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .wrap_stb (wrap_stb),
        .in_word  (cap_word),
        .in_vld   (cap_vld),
        .out_word (pipe_word),
        .out_vld  (pipe_vld)
    );

    sertx_shifter #(.WORD_W(WORD_W)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .load     (wrap_stb),
        .word     (pipe_word),
        .word_vld (pipe_vld),
        .ser_out  (ser_out)
    );
endmodule

// File: rtl/sertx_chk.sv
// Module: sertx_chk
// Property checker for sertx_top, attached by bind below.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic ser_out,
    input logic ref_clk,
    input logic mode_q,
    input logic wrap_stb,
    input logic mid_stb
);
    AST_SER_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out)); // R5

    AST_REF_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ref_clk)); // R5

    AST_REF_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_stb |=> ref_clk); // R6

    AST_REF_FALL_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb |=> !ref_clk); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wrap_stb, mid_stb})); // R1

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q)); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && ref_clk)); // R8
endmodule

bind sertx_top sertx_chk i_sertx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .ser_out  (ser_out),
    .ref_clk  (ref_clk),
    .mode_q   (mode_q),
    .wrap_stb (wrap_stb),
    .mid_stb  (mid_stb)
);

// File: tb/test_sertx_top.sv
// Bench: behavioural model maps each enable count to the bit expected on
// ser_out and the expected ref_clk level; compared every cycle.
module test_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       mode_ddr = 1'b0;
    logic [9:0] tx_data = '0;
    logic       ref_clk;
    logic       ser_out;

    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;
    int   tick = 0;
    bit   model_ddr = 1'b0;
    bit   lo_ok = 1'b0;
    logic [4:0] lo_half = '0;
    logic exp_bit [0:4095];

    always #4 clk = ~clk; // 125 MHz

    sertx_top i_sertx_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .mode_ddr (mode_ddr),
        .tx_data  (tx_data),
        .ref_clk  (ref_clk),
        .ser_out  (ser_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s tick=%0d actual=%0d expected=%0d", req, tick, act, expv);
        end
    endtask

    // Compare outputs with the model (called away from the clock edge).
    task automatic compare(input string req);
        logic eb;
        logic er;
        eb = (tick < 4096) ? exp_bit[tick] : 1'b0;
        er = ((tick % 10) < 5);
        chk(ser_out === eb, req, int'(ser_out), int'(eb));
        chk(ref_clk === er, "R6 ref_clk", int'(ref_clk), int'(er));
    endtask

    // Record what the next edge captures, per R2/R3/R4.
    task automatic model_tick(input logic [9:0] d);
        logic [9:0] w;
        tick++;
        if (tick % 10 == 0 && tick + 30 < 4096) begin
            if (!model_ddr) begin
                for (int i = 0; i < 10; i++) exp_bit[tick + 10 + i] = d[i]; // R2: 19 to bit 9
            end else begin
                lo_half = d[4:0];
                lo_ok = 1'b1;
            end
        end else if (tick % 10 == 5 && model_ddr && lo_ok && tick + 30 < 4096) begin
            w = {d[4:0], lo_half}; // R3: upper input lines ignored
            for (int i = 0; i < 10; i++) exp_bit[tick + 15 + i] = w[i]; // R3: 29 to bit 9
        end
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b1; // enables during reset must not count
        mode_ddr = m;
        repeat (3) @(negedge clk);
        chk(ser_out === 1'b0, "R8 reset ser_out", int'(ser_out), 0);
        chk(ref_clk === 1'b1, "R8 reset ref_clk", int'(ref_clk), 1);
        for (int i = 0; i < 4096; i++) exp_bit[i] = 1'b0;
        tick = 0;
        lo_ok = 1'b0;
        model_ddr = m;
        rst_n = 1'b1;
        bit_en = 1'b0;
    endtask

    // pat: 0 random, 1 all ones, 2 alternating; gaps: stall probability in %
    task automatic run(input int n, input int gaps, input int pat, input string req);
        logic [9:0] d;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare(req);
            case (pat)
                1:       d = 10'h3FF;
                2:       d = (tick % 20 < 10) ? 10'h2AA : 10'h155;
                default: d = 10'($urandom);
            endcase
            tx_data = d;
            bit_en = ($urandom_range(99) >= gaps);
            if (bit_en) model_tick(d);
        end
        @(negedge clk);
        compare(req);
        bit_en = 1'b0;
    endtask

    initial begin
        // Ten-bit mode, back-to-back enables: R1, R2, R4
        do_reset(1'b0);
        run(60, 0, 1, "R4 first word ten-bit");
        run(300, 0, 0, "R2 ten-bit random");
        run(100, 0, 2, "R1 alternating no gap");
        // Stalls: R5
        run(400, 40, 0, "R5 stalled enables");
        // Mode pin change after reset is ignored: R7
        mode_ddr = 1'b1;
        run(200, 10, 0, "R7 mode pin ignored (ten-bit)");
        // Double-rate mode: R3, R4
        do_reset(1'b1);
        run(60, 0, 1, "R4 first word double-rate");
        run(400, 0, 0, "R3 double-rate random");
        run(300, 30, 2, "R3 double-rate stalled");
        mode_ddr = 1'b0;
        run(200, 0, 0, "R7 mode pin ignored (double-rate)");
        // Reset mid-stream returns to a low output: R8
        do_reset(1'b0);
        run(40, 0, 0, "R8 after re-reset");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule